// File: doc/BRIEF.md
# Unaligned Access Sequencer

This block sits between a load/store unit and a data memory port that is one 32-bit word wide. It takes one request at a time: a base address, an index offset, an access size (byte, halfword, word, doubleword, or a run of words with a word count), a direction, and a legacy-mode flag. From the sum of base and offset it works out which aligned words the access touches. It then issues one word transaction per touched word, strictly in ascending address order. Each transaction carries a byte-enable mask that covers only the bytes belonging to the request. Store bytes are steered onto the matching lanes. Load bytes are gathered into a holding register and handed back together with a single valid pulse.

Whenever the base or the offset has nonzero low bits, address formation takes one extra cycle before the first transaction. The request side is held not-ready from acceptance until the cycle after the last piece completes. The pieces of a split access are independent memory transactions, and no locking is held across them.

In legacy mode a word load is not split. It reads the word at the address with its low two bits cleared and rotates the returned data right by eight bits per byte of misalignment. Word stores, doublewords and multi-word runs in legacy mode ignore the low two address bits.

Top module: `uls_sequencer`

## Requirements
- R1: While reset is asserted and after its release, req_ready is 1, and mem_valid and ld_valid are 0.
- R2: The effective address is base plus offset. If both base[1:0] and offset[1:0] are zero, the first transaction is presented in the cycle after acceptance. Otherwise it is presented two cycles after acceptance.
- R3: Transaction addresses are word aligned. The first one is the effective address with its low two bits cleared, and each following one is the previous address plus 4. The number of transactions is the number of words spanned by the request bytes (one for a legacy word load).
- R4: Bytes are little-endian: request byte i lives at effective address plus i and travels on bits [8i+7:8i] of req_wdata and ld_data. In each transaction, mem_be bit l is set exactly when address (transaction address + l) holds a request byte.
- R5: For a load, ld_valid pulses for one cycle, in the cycle after the final transaction is acknowledged. ld_data byte i then equals memory byte (effective address + i) for every request byte, and zero above the request length.
- R6: A store writes exactly the request bytes, through mem_we and mem_be. It produces no ld_valid pulse.
- R7: req_ready stays 0 from acceptance until the cycle after the final acknowledge. While mem_ack is 0, mem_addr and mem_be hold their values.
- R8: A legacy word load issues one transaction with mem_be 4'b1111 at the aligned address. ld_data byte i equals that word's byte ((i + addr[1:0]) mod 4), which is a right rotation by 8*addr[1:0] bits.
- R9: In legacy mode, word stores, doublewords and multi-word runs treat addr[1:0] as zero. The run starts at the aligned address, and each following word adds 4.
- R10: req_size encodes 0 byte, 1 halfword, 2 word, 3 doubleword, 4 multi-word, and other codes act as byte. A multi-word count of 0 acts as 1, and counts above MAX_WORDS act as MAX_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when both are high |
| req_base | input | ADDR_W | Base address |
| req_offset | input | ADDR_W | Index offset added to base |
| req_size | input | 3 | Access size code |
| req_count | input | $clog2(MAX_WORDS+1) | Word count for multi-word |
| req_store | input | 1 | 1 store, 0 load |
| req_legacy | input | 1 | Legacy mode (rotate loads, align the rest) |
| req_wdata | input | 32*MAX_WORDS | Store bytes, byte 0 in the low bits |
| mem_valid | output | 1 | Word transaction presented |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_addr | output | ADDR_W | Word-aligned transaction address |
| mem_we | output | 1 | Write transaction |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ld_valid | output | 1 | One-cycle load completion pulse |
| ld_data | output | 32*MAX_WORDS | Assembled load bytes |

## Verification
If the request is accepted at clock edge n, the first transaction is visible after edge n+1 when base and offset are aligned, and after edge n+2 otherwise. A transaction acknowledged at edge m is followed by the next address after m. The load pulse and the return of req_ready both appear after the edge that takes the final acknowledge. The bench drives inputs and samples outputs on the falling edge, counts falling edges from acceptance to check the first-transaction latency, logs each acknowledged transaction, and compares the load data and its memory model against values computed from address arithmetic. It sweeps every size, every low-address offset, both modes, both directions, aligned and misaligned base/offset splits, and an acknowledge pattern that stalls every other cycle.

// File: rtl/uls_pkg.sv
package uls_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_MULTI = 3'd4
  } uls_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_ISSUE = 2'd2
  } uls_state_e;
endpackage

// File: rtl/uls_addr_plan.sv
// Address formation and span planning for one request (combinational).
module uls_addr_plan
  import uls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 4,
  localparam int CW   = $clog2(MAX_WORDS + 1),
  localparam int BB   = MAX_WORDS * 4,
  localparam int NB_W = $clog2(BB + 1),
  localparam int TX_W = $clog2(MAX_WORDS + 2)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic [2:0]        size,
  input  logic [CW-1:0]     count,
  input  logic              store,
  input  logic              legacy,
  output logic [ADDR_W-1:0] waddr,
  output logic              slow,
  output logic [1:0]        start,
  output logic [NB_W-1:0]   nbytes,
  output logic              rotate,
  output logic [TX_W-1:0]   nwords
);
  logic [ADDR_W-1:0] eff;
  logic [CW-1:0]     cnt_sel;
  logic              force_al;
  logic [NB_W:0]     span;

  always_comb begin
    eff   = base + offset;
    waddr = {eff[ADDR_W-1:2], 2'b00};
    slow  = (base[1:0] != 2'b00) || (offset[1:0] != 2'b00);

    if (count == '0)
      cnt_sel = CW'(1);
    else if (count > CW'(MAX_WORDS))
      cnt_sel = CW'(MAX_WORDS);
    else
      cnt_sel = count;

    case (size)
      SZ_HALF:  nbytes = NB_W'(2);
      SZ_WORD:  nbytes = NB_W'(4);
      SZ_DWORD: nbytes = NB_W'(8);
      SZ_MULTI: nbytes = NB_W'({cnt_sel, 2'b00});
      default:  nbytes = NB_W'(1);
    endcase

    force_al = legacy && ((size == SZ_WORD && store) || size == SZ_DWORD || size == SZ_MULTI);
    rotate   = legacy && (size == SZ_WORD) && !store;
    start    = force_al ? 2'b00 : eff[1:0];
    span     = (NB_W+1)'(start) + (NB_W+1)'(nbytes) + (NB_W+1)'(3);
    nwords   = rotate ? TX_W'(1) : TX_W'(span >> 2);
  end
endmodule

// File: rtl/uls_lane_map.sv
// Per-lane mapping of one word transaction onto request byte positions.
module uls_lane_map #(
  parameter int MAX_WORDS = 4,
  localparam int BB   = MAX_WORDS * 4,
  localparam int NB_W = $clog2(BB + 1),
  localparam int TX_W = $clog2(MAX_WORDS + 2),
  localparam int BI_W = $clog2(BB)
) (
  input  logic [TX_W-1:0]           tx_idx,
  input  logic [1:0]                start,
  input  logic [NB_W-1:0]           nbytes,
  input  logic                      rotate,
  output logic [3:0]                hit,
  output logic [3:0][BI_W-1:0]      pos
);
  localparam int PW = NB_W + TX_W + 1;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [PW-1:0] ext;
    logic [PW-1:0] rel;
    logic [1:0]    rot_pos;
    logic          in_rng;

    always_comb begin
      // ext is the request byte index plus 4, so it stays non-negative
      ext     = PW'({tx_idx, 2'b00}) + PW'(l) + PW'(4) - PW'(start);
      rel     = ext - PW'(4);
      in_rng  = (ext >= PW'(4)) && (rel < PW'(nbytes));
      rot_pos = 2'(l) - start;
      hit[l]  = rotate || in_rng;
      pos[l]  = rotate ? BI_W'(rot_pos) : BI_W'(rel);
    end
  end
endmodule

// File: rtl/uls_load_merge.sv
// Holding register that gathers load bytes from successive word returns.
module uls_load_merge #(
  parameter int MAX_WORDS = 4,
  localparam int BB   = MAX_WORDS * 4,
  localparam int BI_W = $clog2(BB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  capture,
  input  logic [3:0]            hit,
  input  logic [3:0][BI_W-1:0]  pos,
  input  logic [31:0]           rdata,
  output logic [BB*8-1:0]       data
);
  logic [BB*8-1:0] hold_q;
  logic [BB*8-1:0] hold_d;
  logic            hold_en;

  always_comb begin
    hold_d  = hold_q;
    hold_en = clear || capture;
    if (clear) begin
      hold_d = '0;
    end else if (capture) begin
      for (int l = 0; l < 4; l++) begin
        if (hit[l]) hold_d[8*pos[l] +: 8] = rdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign data = hold_q;
endmodule

// File: rtl/uls_sequencer.sv
module uls_sequencer
  import uls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 4,
  localparam int CW    = $clog2(MAX_WORDS + 1),
  localparam int BUF_W = MAX_WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [2:0]        req_size,
  input  logic [CW-1:0]     req_count,
  input  logic              req_store,
  input  logic              req_legacy,
  input  logic [BUF_W-1:0]  req_wdata,
  output logic              mem_valid,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [BUF_W-1:0]  ld_data
);
  localparam int BB   = MAX_WORDS * 4;
  localparam int NB_W = $clog2(BB + 1);
  localparam int TX_W = $clog2(MAX_WORDS + 2);
  localparam int BI_W = $clog2(BB);

  // planner outputs
  logic [ADDR_W-1:0] p_waddr;
  logic              p_slow;
  logic [1:0]        p_start;
  logic [NB_W-1:0]   p_nbytes;
  logic              p_rotate;
  logic [TX_W-1:0]   p_nwords;

  // request state
  uls_state_e        state_q, state_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [TX_W-1:0]   nwords_q;
  logic [NB_W-1:0]   nbytes_q;
  logic [1:0]        start_q;
  logic              rot_q;
  logic              store_q;
  logic [BUF_W-1:0]  st_q;
  logic              ldv_q, ldv_d;

  logic              accept, fire, last_tx, step_en;
  logic [3:0]        lane_hit;
  logic [3:0][BI_W-1:0] lane_pos;

  uls_addr_plan #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_plan (
    .base   (req_base),
    .offset (req_offset),
    .size   (req_size),
    .count  (req_count),
    .store  (req_store),
    .legacy (req_legacy),
    .waddr  (p_waddr),
    .slow   (p_slow),
    .start  (p_start),
    .nbytes (p_nbytes),
    .rotate (p_rotate),
    .nwords (p_nwords)
  );

  uls_lane_map #(.MAX_WORDS(MAX_WORDS)) u_lanes (
    .tx_idx (tx_q),
    .start  (start_q),
    .nbytes (nbytes_q),
    .rotate (rot_q),
    .hit    (lane_hit),
    .pos    (lane_pos)
  );

  uls_load_merge #(.MAX_WORDS(MAX_WORDS)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (fire && !store_q),
    .hit     (lane_hit),
    .pos     (lane_pos),
    .rdata   (mem_rdata),
    .data    (ld_data)
  );

  // handshake and next state
  always_comb begin
    req_ready = (state_q == ST_IDLE);
    mem_valid = (state_q == ST_ISSUE);
    accept    = req_valid && req_ready;
    fire      = mem_valid && mem_ack;
    last_tx   = (tx_q == nwords_q - TX_W'(1));
    step_en   = accept || fire;

    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = p_slow ? ST_PREP : ST_ISSUE;
      ST_PREP:  state_d = ST_ISSUE;
      ST_ISSUE: if (fire && last_tx) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase

    if (accept) begin
      wa_d = p_waddr;
      tx_d = '0;
    end else begin
      wa_d = wa_q + ADDR_W'(4);
      tx_d = tx_q + TX_W'(1);
    end

    ldv_d = fire && last_tx && !store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ldv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ldv_q   <= ldv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      tx_q <= '0;
    end else if (step_en) begin
      wa_q <= wa_d;
      tx_q <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nwords_q <= '0;
      nbytes_q <= '0;
      start_q  <= '0;
      rot_q    <= 1'b0;
      store_q  <= 1'b0;
      st_q     <= '0;
    end else if (accept) begin
      nwords_q <= p_nwords;
      nbytes_q <= p_nbytes;
      start_q  <= p_start;
      rot_q    <= p_rotate;
      store_q  <= req_store;
      st_q     <= req_wdata;
    end
  end

  // store lane steering
  for (genvar l = 0; l < 4; l++) begin : g_wlane
    assign mem_wdata[8*l +: 8] = lane_hit[l] ? st_q[8*lane_pos[l] +: 8] : 8'h00;
  end

  assign mem_addr = wa_q;
  assign mem_be   = mem_valid ? lane_hit : 4'b0000;
  assign mem_we   = mem_valid && store_q;
  assign ld_valid = ldv_q;

  // checks next to the sequencing logic
  assert_ready_low_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)));
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ack) |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(4)));
  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));
  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != 4'b0000));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
  assert_no_pulse_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !store_q);
  assert_rotate_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && rot_q) |-> (mem_be == 4'b1111));
endmodule

// File: tb/sim_uls_sequencer.sv
`timescale 1ns/1ps
module sim_uls_sequencer;
  localparam int AW = 32;
  localparam int MW = 4;
  localparam int CW = 3;
  localparam int BB = MW * 4;
  localparam int BW = MW * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_base, req_offset;
  logic [2:0]    req_size;
  logic [CW-1:0] req_count;
  logic          req_store, req_legacy;
  logic [BW-1:0] req_wdata;
  logic          mem_valid, mem_ack, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          ld_valid;
  logic [BW-1:0] ld_data;

  logic [7:0] mem  [64];
  logic [7:0] emem [64];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uls_sequencer #(.ADDR_W(AW), .MAX_WORDS(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
    .req_count(req_count), .req_store(req_store), .req_legacy(req_legacy),
    .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  assign mem_rdata = {mem[{mem_addr[5:2], 2'd3}], mem[{mem_addr[5:2], 2'd2}],
                      mem[{mem_addr[5:2], 2'd1}], mem[{mem_addr[5:2], 2'd0}]};

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  task automatic run_req(input int size, input int cnt, input bit st, input bit leg,
                         input bit variant, input int off, input int seed);
    int nb, s, nw, first, ntx, pulses, hold_bad, c;
    bit force_al, rot, slow, pend, done;
    logic [AW-1:0] eff, wa0, pend_addr;
    logic [AW-1:0] rec_addr [8];
    logic [3:0]    rec_be   [8];
    logic [BW-1:0] got_ld, exp_ld, wd;
    logic [3:0]    ebe;
    string tag;

    eff = 32'h114 + AW'(off);
    case (size)
      1: nb = 2;
      2: nb = 4;
      3: nb = 8;
      4: nb = 4 * ((cnt == 0) ? 1 : ((cnt > MW) ? MW : cnt));
      default: nb = 1;
    endcase
    force_al = leg && ((size == 2 && st) || size == 3 || size == 4);
    rot      = leg && size == 2 && !st;
    s        = force_al ? 0 : off;
    nw       = rot ? 1 : (s + nb + 3) / 4;
    wa0      = eff & ~32'h3;
    slow     = variant || (off != 0);

    for (int a = 0; a < 64; a++) begin
      mem[a]  = 8'(a * 7 + seed);
      emem[a] = 8'(a * 7 + seed);
    end
    for (int i = 0; i < BB; i++) wd[8*i +: 8] = 8'(8'hA0 + i + seed);

    // expected load bytes
    exp_ld = '0;
    for (int i = 0; i < BB; i++) begin
      if (i < nb) begin
        if (rot) exp_ld[8*i +: 8] = mem[int'(wa0[5:0]) + ((i + off) & 3)];
        else     exp_ld[8*i +: 8] = mem[int'(wa0[5:0]) + s + i];
      end
    end
    if (st) for (int i = 0; i < nb; i++) emem[int'(wa0[5:0]) + s + i] = wd[8*i +: 8];

    if (variant) begin
      req_base = eff - 32'd2; req_offset = 32'd2;
    end else begin
      req_base = eff - 32'd16; req_offset = 32'd16;
    end
    req_size = 3'(size); req_count = CW'(cnt); req_store = st; req_legacy = leg;
    req_wdata = wd; req_valid = 1'b1;

    first = 0; ntx = 0; pulses = 0; hold_bad = 0; pend = 0; done = 0;
    pend_addr = '0; got_ld = '0;
    for (int k = 0; k < 8; k++) begin rec_addr[k] = '0; rec_be[k] = '0; end
    $sformat(tag, "sz%0d cnt%0d st%0d leg%0d v%0d off%0d", size, cnt, st, leg, variant, off);

    chk(req_ready == 1'b1, {"R7 ready before accept ", tag}, BW'(req_ready), BW'(1));

    for (c = 1; c < 80 && !done; c++) begin
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      mem_ack = variant ? ~mem_ack : 1'b1;
      if (pend && !(mem_valid && mem_addr == pend_addr)) hold_bad++;
      if (mem_valid && req_ready) hold_bad++;
      pend      = mem_valid && !mem_ack;
      pend_addr = mem_addr;
      if (mem_valid && first == 0) first = c;
      if (mem_valid && mem_ack) begin
        if (ntx < 8) begin rec_addr[ntx] = mem_addr; rec_be[ntx] = mem_be; end
        ntx++;
        if (mem_we)
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[int'(mem_addr[5:0]) + l] = mem_wdata[8*l +: 8];
      end
      if (ld_valid) begin pulses++; got_ld = ld_data; end
      if (req_ready) done = 1;
    end

    chk(done, {"R7 ready returns ", tag}, BW'(done), BW'(1));
    chk(first == (slow ? 2 : 1), {"R2 first issue latency ", tag}, BW'(first), BW'(slow ? 2 : 1));
    chk(ntx == nw, {"R3 transaction count ", tag}, BW'(ntx), BW'(nw));
    chk(hold_bad == 0, {"R7 hold and busy ", tag}, BW'(hold_bad), BW'(0));
    for (int k = 0; k < nw && k < 8; k++) begin
      ebe = '0;
      for (int l = 0; l < 4; l++) begin
        int p;
        p = 4 * k + l - s;
        if (rot || (p >= 0 && p < nb)) ebe[l] = 1'b1;
      end
      chk(rec_addr[k] == wa0 + AW'(4 * k),
          {force_al ? "R9 aligned run address " : "R3 word address ", tag},
          BW'(rec_addr[k]), BW'(wa0 + AW'(4 * k)));
      chk(rec_be[k] == ebe, {rot ? "R8 full mask " : "R4 byte enables ", tag},
          BW'(rec_be[k]), BW'(ebe));
    end
    if (st) begin
      int bad;
      bad = 0;
      for (int a = 0; a < 64; a++) if (mem[a] !== emem[a]) bad++;
      chk(bad == 0, {force_al ? "R9 aligned store bytes " : "R6 store bytes ", tag},
          BW'(bad), BW'(0));
      chk(pulses == 0, {"R6 no load pulse ", tag}, BW'(pulses), BW'(0));
    end else begin
      chk(pulses == 1, {"R5 single load pulse ", tag}, BW'(pulses), BW'(1));
      chk(got_ld == exp_ld, {rot ? "R8 rotated load " : (size == 4 ? "R10 multi load " : "R5 load data "), tag},
          got_ld, exp_ld);
    end
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; req_valid = 1'b0; mem_ack = 1'b1;
    req_base = '0; req_offset = '0; req_size = '0; req_count = '0;
    req_store = 1'b0; req_legacy = 1'b0; req_wdata = '0;
    for (int a = 0; a < 64; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_valid && !ld_valid, "R1 outputs in reset",
        BW'({req_ready, mem_valid, ld_valid}), BW'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !ld_valid, "R1 outputs after release",
        BW'({req_ready, mem_valid, ld_valid}), BW'(3'b100));

    seed = 1;
    for (int sz = 0; sz < 13; sz++)
      for (int leg = 0; leg < 2; leg++)
        for (int st = 0; st < 2; st++)
          for (int v = 0; v < 2; v++)
            for (int off = 0; off < 4; off++) begin
              // sz 12 exercises an unused size code, which acts as byte (R10)
              run_req((sz < 4) ? sz : ((sz == 12) ? 6 : 4), (sz < 4 || sz == 12) ? 0 : sz - 4,
                      st[0], leg[0], v[0], off, seed);
              seed++;
            end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule